// File: doc/BRIEF.md
# Dual-Rate Credit Shaper

This block sits in a stream path between a bursty producer and an output link, and it enforces two limits on that path. The first is a sustained-rate credit bucket. Credit builds up at a programmable fraction of a unit per rate tick, and it is held up to a programmable depth. The second is a peak-rate ceiling, expressed as a minimum number of clock cycles between two transfers. A unit of data can pass only when both limits allow it. Each unit that passes spends one credit.

Starting from a full bucket under a steady backlog, the output first runs at the peak spacing until the stored credit is spent. After that it follows the sustained rate. Data is not held inside the block. The input and output handshakes are combined directly:
- The downstream side can stall the producer.
- A closed gate stalls the producer and also suppresses the output valid.
- Credit is spent only on a completed output handshake.

The two status pins report the current credit level and whether a waiting unit is held back by the shaper itself. Configuration pins are expected to change only while no traffic flows.

Top module: `dual_rate_shaper`

## Requirements
- R1: After a synchronous reset (rst_n low across at least one rising edge), token_level equals cfg_depth and the spacing timer is clear, so a unit offered in the first cycle after reset passes at once.
- R2: When token_level is 0, out_valid and in_ready are both low whatever in_valid and out_ready are.
- R3: Each completed transfer (out_valid and out_ready high at a rising edge) lowers token_level by exactly one at that edge when no credit is added in the same cycle.
- R4: Each cycle with rate_tick high adds cfg_rate/256 of a credit to an 8-bit fractional accumulator that starts at 0 after reset. token_level rises by one at each edge where that accumulator carries; cfg_rate = 128 gives one credit every second tick.
- R5: token_level never exceeds cfg_depth. A credit earned while the bucket is full is discarded.
- R6: After a transfer at an edge, no further transfer happens until cfg_gap cycles have passed. cfg_gap values 0 and 1 both allow a transfer every cycle.
- R7: When a credit is earned and a transfer completes at the same edge, token_level is unchanged, including when the bucket is full.
- R8: stalled is high exactly when in_valid is high and the gate is closed, either by an empty bucket or by the spacing timer. While stalled is high, in_ready is low.
- R9: out_data always equals in_data. While out_ready is low, in_ready is low and no credit is spent, and out_valid still reflects an open gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_depth | input | DEPTH_W | Bucket capacity in credits |
| cfg_rate | input | FRAC_W | Credit fraction added per rate tick (value/2^FRAC_W) |
| cfg_gap | input | GAP_W | Minimum cycles between transfers |
| rate_tick | input | 1 | Enables one accrual step this cycle |
| in_valid | input | 1 | Producer offers a unit |
| in_data | input | DATA_W | Producer data |
| in_ready | output | 1 | Unit is accepted this cycle |
| out_valid | output | 1 | Unit presented to the link |
| out_data | output | DATA_W | Data toward the link |
| out_ready | input | 1 | Link accepts the unit |
| token_level | output | DEPTH_W | Current whole-credit count |
| stalled | output | 1 | Waiting unit held back by the shaper |

## Verification
Credit accrual and credit spending can land on the same edge. The risky case is a full bucket, where a careless clamp either loses the spend or saturates the level before subtracting. To provoke it, the bench ticks the accumulator once while idle and full, leaving it half charged. It then streams back to back with one tick per cycle, so the very first transfer coincides with a carry. The level is judged after every edge against a count derived from the tick and transfer pattern. It must read full, then drop by one every second cycle.

// File: rtl/shaper_pkg.sv
package shaper_pkg;

  // Reason the release gate is open or shut in a given cycle.
  typedef enum logic [1:0] {
    GATE_OPEN      = 2'd0,
    GATE_NO_CREDIT = 2'd1,
    GATE_SPACING   = 2'd2
  } gate_e;

endpackage

// File: rtl/credit_bucket.sv
module credit_bucket #(
  parameter int DEPTH_W = 8,
  parameter int FRAC_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DEPTH_W-1:0] depth_i,
  input  logic [FRAC_W-1:0]  rate_i,
  input  logic               tick_i,
  input  logic               take_i,
  output logic [DEPTH_W-1:0] level_o,
  output logic               avail_o
);

  localparam int SUM_W = DEPTH_W + 1;

  logic [FRAC_W-1:0] frac_q;
  logic [FRAC_W:0]   frac_sum;
  logic              earn;
  logic [SUM_W-1:0]  with_earn;
  logic [SUM_W-1:0]  after_take;
  logic [DEPTH_W-1:0] level_d;

  always_comb begin
    frac_sum   = {1'b0, frac_q} + {1'b0, rate_i};
    earn       = tick_i & frac_sum[FRAC_W];
    with_earn  = {1'b0, level_o} + {{DEPTH_W{1'b0}}, earn};
    // Subtract before clamping so a full bucket that earns and spends stays full.
    after_take = (take_i && (with_earn != '0)) ? with_earn - SUM_W'(1) : with_earn;
    level_d    = (after_take > {1'b0, depth_i}) ? depth_i : after_take[DEPTH_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_o <= depth_i;
      frac_q  <= '0;
    end else begin
      level_o <= level_d;
      if (tick_i) frac_q <= frac_sum[FRAC_W-1:0];
    end
  end

  assign avail_o = (level_o != '0);

  assert_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(depth_i) |-> (level_o <= depth_i));

  assert_no_take_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> (level_o != '0));

  assert_take_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !earn) |=> (!$stable(depth_i) || (level_o == $past(level_o) - 1'b1)));

  assert_pair_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && earn) |=> (!$stable(depth_i) || $stable(level_o)));

endmodule

// File: rtl/release_spacer.sv
module release_spacer #(
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GAP_W-1:0] gap_i,
  input  logic             fire_i,
  output logic             open_o
);

  logic [GAP_W-1:0] wait_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_q <= '0;
    end else if (fire_i) begin
      wait_q <= (gap_i > GAP_W'(1)) ? gap_i - GAP_W'(1) : '0;
    end else if (wait_q != '0) begin
      wait_q <= wait_q - GAP_W'(1);
    end
  end

  assign open_o = (wait_q == '0);

  assert_gap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && (gap_i > GAP_W'(1))) |=> !open_o);

  assert_fire_when_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |-> open_o);

endmodule

// File: rtl/dual_rate_shaper.sv
module dual_rate_shaper
  import shaper_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DEPTH_W = 8,
  parameter int FRAC_W  = 8,
  parameter int GAP_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DEPTH_W-1:0] cfg_depth,
  input  logic [FRAC_W-1:0]  cfg_rate,
  input  logic [GAP_W-1:0]   cfg_gap,
  input  logic               rate_tick,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  in_data,
  output logic               in_ready,
  output logic               out_valid,
  output logic [DATA_W-1:0]  out_data,
  input  logic               out_ready,
  output logic [DEPTH_W-1:0] token_level,
  output logic               stalled
);

  gate_e gate;
  logic  has_credit;
  logic  spacing_open;
  logic  fire;

  credit_bucket #(
    .DEPTH_W(DEPTH_W),
    .FRAC_W (FRAC_W)
  ) u_bucket (
    .clk    (clk),
    .rst_n  (rst_n),
    .depth_i(cfg_depth),
    .rate_i (cfg_rate),
    .tick_i (rate_tick),
    .take_i (fire),
    .level_o(token_level),
    .avail_o(has_credit)
  );

  release_spacer #(
    .GAP_W(GAP_W)
  ) u_spacer (
    .clk   (clk),
    .rst_n (rst_n),
    .gap_i (cfg_gap),
    .fire_i(fire),
    .open_o(spacing_open)
  );

  always_comb begin
    if (!has_credit)        gate = GATE_NO_CREDIT;
    else if (!spacing_open) gate = GATE_SPACING;
    else                    gate = GATE_OPEN;
  end

  assign out_valid = in_valid && (gate == GATE_OPEN);
  assign in_ready  = out_ready && (gate == GATE_OPEN);
  assign out_data  = in_data;
  assign fire      = out_valid && out_ready;
  assign stalled   = in_valid && (gate != GATE_OPEN);

  assert_stall_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |-> !in_ready);

  assert_backpressure_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |-> !in_ready);

  assert_empty_closed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (token_level == '0) |-> (!out_valid && !in_ready));

  assert_level_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_ready && !rate_tick) |=> (!$stable(cfg_depth) || $stable(token_level)));

endmodule

// File: tb/sim_dual_rate_shaper.sv
`timescale 1ns/1ps
module sim_dual_rate_shaper;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_depth = 8'd4;
  logic [7:0] cfg_rate = 8'd0;
  logic [3:0] cfg_gap = 4'd1;
  logic       rate_tick = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'd0;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_ready = 1'b0;
  logic [7:0] token_level;
  logic       stalled;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dual_rate_shaper u0 (
    .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_rate(cfg_rate),
    .cfg_gap(cfg_gap), .rate_tick(rate_tick), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready), .token_level(token_level),
    .stalled(stalled)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input int depth, input int rate, input int gap);
    @(negedge clk);
    in_valid = 0; out_ready = 0; rate_tick = 0;
    cfg_depth = 8'(depth); cfg_rate = 8'(rate); cfg_gap = 4'(gap);
    rst_n = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_reset_state();
    do_reset(4, 0, 1);
    #1;
    chk("R1 level", token_level, 4);
    in_valid = 1; out_ready = 1; in_data = 8'h5a;
    #1;
    chk("R1 first unit passes", out_valid, 1);
    chk("R1 in_ready", in_ready, 1);
    in_valid = 0;
  endtask

  task automatic t_drain();
    do_reset(4, 0, 1);
    in_valid = 1; out_ready = 1;
    for (int k = 0; k < 6; k++) begin
      if (k > 0) @(negedge clk);
      in_data = 8'(8'h30 + k);
      #1;
      chk("R3 level", token_level, (k < 4) ? 4 - k : 0);
      chk("R2 out_valid", out_valid, (k < 4) ? 1 : 0);
      chk("R9 out_data", out_data, 8'h30 + k);
      if (k >= 4) begin
        chk("R2 in_ready low", in_ready, 0);
        chk("R8 stalled on empty", stalled, 1);
      end
    end
    @(negedge clk);
    in_valid = 0;
    #1;
    chk("R8 no stall when idle", stalled, 0);
  endtask

  task automatic t_accrual();
    // Bucket empty after drain; accumulator still at 0.
    cfg_rate = 8'd128; rate_tick = 1;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      #1;
      chk("R4 half-credit accrual", token_level, i / 2);
    end
    rate_tick = 0;
  endtask

  task automatic t_saturate();
    do_reset(3, 200, 1);
    rate_tick = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      #1;
      chk("R5 level capped", token_level, 3);
    end
    rate_tick = 0;
  endtask

  task automatic t_backpressure();
    do_reset(4, 0, 1);
    in_valid = 1; out_ready = 0;
    for (int k = 0; k < 3; k++) begin
      if (k > 0) @(negedge clk);
      in_data = 8'(8'hc0 + k);
      #1;
      chk("R9 out_valid shown", out_valid, 1);
      chk("R9 in_ready low", in_ready, 0);
      chk("R9 no spend", token_level, 4);
      chk("R8 not stalled by link", stalled, 0);
      chk("R9 data", out_data, 8'hc0 + k);
    end
    in_valid = 0;
  endtask

  task automatic t_coincide();
    do_reset(4, 128, 1);
    rate_tick = 1;                 // one idle tick: full, accumulator half charged
    @(negedge clk);
    in_valid = 1; out_ready = 1;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      #1;
      chk("R7 earn and spend", token_level, 4 - k / 2);
    end
    in_valid = 0; rate_tick = 0;
  endtask

  task automatic t_peak();
    do_reset(4, 0, 3);
    in_valid = 1; out_ready = 1;
    for (int k = 0; k < 10; k++) begin
      if (k > 0) @(negedge clk);
      #1;
      chk("R6 spacing", out_valid, (k % 3 == 0) ? 1 : 0);
      chk("R8 stall by spacing", stalled, (k % 3 == 0) ? 0 : 1);
      chk("R6 level", token_level, 4 - (k + 2) / 3);
    end
    in_valid = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    t_reset_state();
    t_drain();
    t_accrual();
    t_saturate();
    t_backpressure();
    t_coincide();
    t_peak();
    @(negedge clk);
    finish_run();
  end

endmodule